// File: doc/BRIEF.md
# Grouped Interrupt Request Aggregator

This block gathers level-sensitive interrupt requests from peripheral devices and merges them into one interrupt line for a processor core. Requests are arranged in three groups: a small basic group of `BASIC_W` sources and two numbered groups of 32 sources each. Every group has its own enable mask and its own read-only pending word, reached over a simple word-addressed register bus.

A request is sampled into the pending word whether or not it is enabled. Masking therefore only postpones an interrupt and never loses it. The pending bit stays set for as long as the device drives its request, and it falls only when the device withdraws it after software has serviced the device. The basic pending word also carries two summary flags, which tell software which numbered group holds enabled pending work, so that a handler can choose the group to scan.

Top module: `irq_aggregator`

## Requirements
- R1: After reset every enable mask is zero, `irq_o` is low, and reading any enable address returns 0.
- R2: A numbered group's pending word (word address 1 for group 1, 2 for group 2) shows source n of that group in bit n. It holds the request levels sampled one clock earlier, several bits may be set at once, and it does not depend on the enable mask.
- R3: A request whose enable bit is clear stays in the pending word and does not drive `irq_o`. Once its enable bit is set, `irq_o` rises on the second clock edge after the enabling write.
- R4: A write to an enable-set address (3 for basic, 4 for group 1, 5 for group 2) sets each enable bit whose write-data bit is 1. Bits written as 0 are left unchanged.
- R5: A write to an enable-clear address (6 for basic, 7 for group 1, 8 for group 2) clears each enable bit whose write-data bit is 1. Bits written as 0 are left unchanged.
- R6: Reading either the enable-set address or the enable-clear address of a group returns that group's current enable mask.
- R7: Writes to the pending addresses (0, 1, 2) change nothing. A pending bit clears only when its source drops the request. Enable masks change only on writes to their own set or clear address.
- R8: `irq_o` is the OR, over all three groups, of pending AND enable, registered one clock later.
- R9: The basic pending word (address 0) holds the basic group's pending bits in bits [BASIC_W-1:0]. Bit BASIC_W is 1 when group 1 has at least one enabled pending source, and bit BASIC_W+1 is the same flag for group 2. All higher bits read 0, and so do unmapped addresses.
- R10: The timer requests on group-1 sources 1 and 3 raise `irq_o` once they are enabled through the group-1 enable-set register (bits 1 and 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| src_basic_i | input | BASIC_W | Level requests of the basic group |
| src_grp1_i | input | 32 | Level requests of numbered group 1 |
| src_grp2_i | input | 32 | Level requests of numbered group 2 |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Word address of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, 0 when no read is in progress |
| irq_o | output | 1 | Combined interrupt request to the core |

## Verification
On every clock the assertions check three things. Enable-set writes never clear a mask bit, and enable-clear writes never set one. The masks stay unchanged when no write is in progress. The combined interrupt follows any enabled pending source one cycle later. The bench scenarios cover the rest: requests deferred while masked and delivered later, pending bits that ignore writes and fall only when the source withdraws, the readback of masks, and the layout of the summary word. A behavioural model, compared on every clock, also checks the exact timing of `irq_o`.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned GRP_W  = 32;
  localparam int unsigned NUM_GRP = 3;          // 0 = basic, 1 and 2 = numbered
  localparam int unsigned PEND_BASE = 0;        // pending word of group g at g
  localparam int unsigned SET_BASE  = PEND_BASE + NUM_GRP;
  localparam int unsigned CLR_BASE  = SET_BASE + NUM_GRP;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_s_n = sync_q[1];
endmodule

// File: rtl/irq_decode.sv
module irq_decode
  import irq_agg_pkg::*;
(
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic [REG_AW-1:0] addr_i,
  output logic [NUM_GRP-1:0] set_we_o,
  output logic [NUM_GRP-1:0] clr_we_o
);
  logic wr_act;
  assign wr_act = sel_i & wr_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_dec
    assign set_we_o[g] = wr_act & (addr_i == REG_AW'(SET_BASE + g));
    assign clr_we_o[g] = wr_act & (addr_i == REG_AW'(CLR_BASE + g));
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] req_i,
  input  logic         set_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] en_o,
  output logic         active_o
);
  logic [W-1:0] pend_q, pend_d;
  logic [W-1:0] en_q, en_d;
  logic         en_load;

  always_comb begin
    pend_d  = req_i;
    en_load = set_we_i | clr_we_i;
    en_d    = en_q;
    if (set_we_i) en_d = en_d | mask_i;
    if (clr_we_i) en_d = en_d & ~mask_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      pend_q <= pend_d;
      if (en_load) en_q <= en_d;
    end
  end

  assign pend_o   = pend_q;
  assign en_o     = en_q;
  assign active_o = |(pend_q & en_q);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned BASIC_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BASIC_W-1:0] src_basic_i,
  input  logic [GRP_W-1:0]   src_grp1_i,
  input  logic [GRP_W-1:0]   src_grp2_i,
  input  logic               bus_sel_i,
  input  logic               bus_wr_i,
  input  logic [REG_AW-1:0]  bus_addr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_o
);
  localparam int unsigned NUM_NUM = NUM_GRP - 1;

  logic               rst_s;
  logic [NUM_GRP-1:0] set_we, clr_we;
  logic [NUM_GRP-1:0] act;
  logic [BASIC_W-1:0] pend_b, en_b;
  logic [GRP_W-1:0]   grp_src  [NUM_NUM];
  logic [GRP_W-1:0]   grp_pend [NUM_NUM];
  logic [GRP_W-1:0]   grp_en   [NUM_NUM];
  logic [DATA_W-1:0]  basic_word;
  logic [DATA_W-1:0]  rd_mux;
  logic               irq_d, irq_q;

  irq_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s_n(rst_s));

  irq_decode u_dec (
    .sel_i(bus_sel_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .set_we_o(set_we), .clr_we_o(clr_we)
  );

  irq_bank #(.W(BASIC_W)) u_bank_b (
    .clk(clk), .rst_n(rst_s), .req_i(src_basic_i),
    .set_we_i(set_we[0]), .clr_we_i(clr_we[0]),
    .mask_i(bus_wdata_i[BASIC_W-1:0]),
    .pend_o(pend_b), .en_o(en_b), .active_o(act[0])
  );

  assign grp_src[0] = src_grp1_i;
  assign grp_src[1] = src_grp2_i;

  for (genvar gi = 0; gi < NUM_NUM; gi++) begin : g_num
    irq_bank #(.W(GRP_W)) u_bank (
      .clk(clk), .rst_n(rst_s), .req_i(grp_src[gi]),
      .set_we_i(set_we[gi+1]), .clr_we_i(clr_we[gi+1]),
      .mask_i(bus_wdata_i[GRP_W-1:0]),
      .pend_o(grp_pend[gi]), .en_o(grp_en[gi]), .active_o(act[gi+1])
    );
  end

  always_comb begin
    basic_word                 = '0;
    basic_word[BASIC_W-1:0]    = pend_b;
    basic_word[BASIC_W]        = act[1];
    basic_word[BASIC_W+1]      = act[2];
  end

  always_comb begin
    rd_mux = '0;
    case (bus_addr_i)
      REG_AW'(PEND_BASE):      rd_mux = basic_word;
      REG_AW'(PEND_BASE + 1):  rd_mux = DATA_W'(grp_pend[0]);
      REG_AW'(PEND_BASE + 2):  rd_mux = DATA_W'(grp_pend[1]);
      REG_AW'(SET_BASE),
      REG_AW'(CLR_BASE):       rd_mux = DATA_W'(en_b);
      REG_AW'(SET_BASE + 1),
      REG_AW'(CLR_BASE + 1):   rd_mux = DATA_W'(grp_en[0]);
      REG_AW'(SET_BASE + 2),
      REG_AW'(CLR_BASE + 2):   rd_mux = DATA_W'(grp_en[1]);
      default:                 rd_mux = '0;
    endcase
  end

  assign bus_rdata_o = (bus_sel_i && !bus_wr_i) ? rd_mux : '0;

  assign irq_d = |act;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int unsigned BASIC_W = 8
) (
  input logic               clk,
  input logic               rst_s,
  input logic               sel,
  input logic               wr,
  input logic [REG_AW-1:0]  addr,
  input logic [BASIC_W-1:0] en_b,
  input logic [GRP_W-1:0]   en_1,
  input logic [GRP_W-1:0]   en_2,
  input logic [NUM_GRP-1:0] act,
  input logic               irq
);
  // R4
  a_r4_set_never_clears: assert property (@(posedge clk) disable iff (!rst_s)
    (sel && wr && addr == REG_AW'(SET_BASE + 1)) |=> (($past(en_1) & ~en_1) == '0));

  // R5
  a_r5_clr_never_sets: assert property (@(posedge clk) disable iff (!rst_s)
    (sel && wr && addr == REG_AW'(CLR_BASE + 1)) |=> ((en_1 & ~$past(en_1)) == '0));

  // R7
  a_r7_masks_hold: assert property (@(posedge clk) disable iff (!rst_s)
    !(sel && wr) |=> ($stable(en_b) && $stable(en_1) && $stable(en_2)));

  // R8
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_s)
    (act != '0) |=> irq);

  // R8
  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rst_s)
    (act == '0) |=> !irq);
endmodule

bind irq_aggregator irq_agg_chk #(.BASIC_W(BASIC_W)) u_chk (
  .clk(clk), .rst_s(rst_s), .sel(bus_sel_i), .wr(bus_wr_i), .addr(bus_addr_i),
  .en_b(en_b), .en_1(grp_en[0]), .en_2(grp_en[1]), .act(act), .irq(irq_o)
);

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;
  localparam int BW = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [BW-1:0] src_b;
  logic [31:0] src_1, src_2;
  logic        sel, wr;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit go = 0;

  always #5 clk = ~clk;

  irq_aggregator #(.BASIC_W(BW)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src_basic_i(src_b), .src_grp1_i(src_1),
    .src_grp2_i(src_2), .bus_sel_i(sel), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  logic [1:0]    m_s;
  logic [BW-1:0] m_pb, m_eb;
  logic [31:0]   m_p1, m_p2, m_e1, m_e2;
  logic          m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s <= 0; m_pb <= 0; m_eb <= 0; m_p1 <= 0; m_p2 <= 0;
      m_e1 <= 0; m_e2 <= 0; m_irq <= 0;
    end else begin
      m_s <= {m_s[0], 1'b1};
      if (!m_s[1]) begin
        m_pb <= 0; m_eb <= 0; m_p1 <= 0; m_p2 <= 0;
        m_e1 <= 0; m_e2 <= 0; m_irq <= 0;
      end else begin
        m_irq <= ((m_pb & m_eb) != 0) || ((m_p1 & m_e1) != 0) || ((m_p2 & m_e2) != 0);
        m_pb <= src_b; m_p1 <= src_1; m_p2 <= src_2;
        if (sel && wr) begin
          case (addr)
            4'd3: m_eb <= m_eb | wdata[BW-1:0];
            4'd4: m_e1 <= m_e1 | wdata;
            4'd5: m_e2 <= m_e2 | wdata;
            4'd6: m_eb <= m_eb & ~wdata[BW-1:0];
            4'd7: m_e1 <= m_e1 & ~wdata;
            4'd8: m_e2 <= m_e2 & ~wdata;
            default: ;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (go) begin
      checks++;
      if (irq !== m_irq) begin
        errors++;
        $display("FAIL R8 per-cycle irq got %0b exp %0b at %0t", irq, m_irq, $time);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; wr = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1; wr = 0; addr = a;
    #1 d = rdata;
    sel = 0;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog expired got 0 exp 1");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    rst_n = 0; src_b = 0; src_1 = 0; src_2 = 0;
    sel = 0; wr = 0; addr = 0; wdata = 0;
    idle(3);
    rst_n = 1;
    idle(4);
    go = 1;

    // R1 reset state
    chk("R1 irq after reset", {31'b0, irq}, 0);
    bus_read(4'd4, rd); chk("R1 group1 enable", rd, 0);
    bus_read(4'd3, rd); chk("R1 basic enable", rd, 0);
    bus_read(4'd8, rd); chk("R1 group2 enable", rd, 0);

    // R2 / R3: timer sources pending while masked
    src_1 = 32'h0000_000A;
    idle(2);
    bus_read(4'd1, rd); chk("R2 group1 pending", rd, 32'h0000_000A);
    chk("R3 masked no irq", {31'b0, irq}, 0);

    // R3 / R10: enable timer source 1, deferred request delivered
    bus_write(4'd4, 32'h0000_0002);
    idle(1);
    chk("R10 timer1 irq", {31'b0, irq}, 1);
    bus_read(4'd4, rd); chk("R6 set readback", rd, 32'h2);
    bus_read(4'd7, rd); chk("R6 clr readback", rd, 32'h2);
    bus_read(4'd0, rd); chk("R9 summary g1", rd, 32'h0000_0100);

    // R4 zero bits have no effect
    bus_write(4'd4, 32'h0);
    bus_read(4'd4, rd); chk("R4 zero write", rd, 32'h2);

    // R5 clear
    bus_write(4'd7, 32'h0000_0002);
    idle(1);
    chk("R5 irq drops", {31'b0, irq}, 0);
    bus_read(4'd4, rd); chk("R5 mask cleared", rd, 0);

    // R7 writes to pending ignored
    bus_write(4'd1, 32'h0);
    bus_write(4'd0, 32'hFFFF_FFFF);
    bus_read(4'd1, rd); chk("R7 pending kept", rd, 32'h0000_000A);
    bus_read(4'd3, rd); chk("R7 basic mask untouched", rd, 0);

    // R10 timer source 3, source 1 withdraws
    bus_write(4'd4, 32'h0000_0008);
    src_1 = 32'h0000_0008;
    idle(2);
    chk("R10 timer3 irq", {31'b0, irq}, 1);
    bus_read(4'd1, rd); chk("R7 pending clears on withdraw", rd, 32'h8);

    // R8 irq follows removal
    src_1 = 0;
    idle(2);
    chk("R8 irq low when idle", {31'b0, irq}, 0);
    bus_read(4'd1, rd); chk("R7 pending empty", rd, 0);

    // R2 / R9 multiple sources across groups
    src_2 = 32'h8000_0001;
    src_b = 8'h20;
    idle(2);
    bus_read(4'd2, rd); chk("R2 group2 multi", rd, 32'h8000_0001);
    bus_read(4'd0, rd); chk("R9 basic no summary", rd, 32'h0000_0020);
    chk("R3 all masked", {31'b0, irq}, 0);

    bus_write(4'd5, 32'h8000_0000);
    idle(1);
    chk("R8 group2 irq", {31'b0, irq}, 1);
    bus_read(4'd0, rd); chk("R9 summary g2", rd, 32'h0000_0220);

    bus_write(4'd8, 32'hFFFF_FFFF);
    bus_write(4'd3, 32'h0000_0020);
    idle(1);
    chk("R8 basic irq", {31'b0, irq}, 1);
    bus_read(4'd0, rd); chk("R9 basic only", rd, 32'h0000_0020);
    bus_read(4'd6, rd); chk("R6 basic clr readback", rd, 32'h20);
    bus_read(4'd5, rd); chk("R5 group2 cleared", rd, 0);
    bus_read(4'd15, rd); chk("R9 unmapped zero", rd, 0);

    src_b = 0; src_2 = 0;
    idle(3);
    chk("R8 final idle", {31'b0, irq}, 0);
    finish_run();
  end
endmodule